// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O peripheral. Its pins are grouped into register sets of 32 pins each. Software picks the direction of every pin and drives output levels through separate write-one-to-set and write-one-to-clear ports, so two agents can change different pins without a read-modify-write. Every pin level is brought through a two-flop synchroniser and can be read back at any time, including while the pin is an output.

Each pin can watch for rising transitions, falling transitions, or both. A detected edge that is enabled is latched in a sticky status bit. Software clears that bit by writing a one to it. Status bits are gathered in groups of 16 pins onto one interrupt line per group, and a global enable register gates each line. Access uses a plain 32-bit register bus with an address, a write strobe, write data and combinational read data.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every pin is an input (direction bit 1 and `pin_oe` low), every output level is 0, all edge enables and status bits read 0, all group enables are 0 and every `bank_irq` line is low.
- R2: The group-enable register is at byte address 0x08, and bit b gates line b; its unused upper bits read 0. Register set s starts at 0x10 + s*0x28. Within a set the word offsets are: direction 0x00, output level 0x04, output-set 0x08, output-clear 0x0C, input level 0x10, rise-enable-set 0x14, rise-enable-clear 0x18, fall-enable-set 0x1C, fall-enable-clear 0x20 and status 0x24. An unmapped address reads 0.
- R3: A direction bit of 1 turns the pin's output driver off (`pin_oe` low). A direction bit of 0 turns it on. The direction register can be read and written directly.
- R4: A write to output-set drives the pins with a 1 in the mask high. A write to output-clear drives them low. Pins with a 0 in the mask keep their level. A write to the output level offset is ignored. Both port offsets read back the current output levels.
- R5: The input level register returns the pin level after two clock edges of synchronisation. This holds whether the pin is an input or an output.
- R6: When a pin's rise enable is set, a 0-to-1 transition of its synchronised level sets its status bit three clock edges after the pin changes.
- R7: When a pin's fall enable is set, a 1-to-0 transition sets its status bit. With both enables set, either transition sets it.
- R8: A transition in a direction whose enable is clear leaves the status bit unchanged.
- R9: Status bits stay set until software writes a 1 to them at the status offset. Written zeros leave bits unchanged.
- R10: If an enabled edge is captured in the same cycle as a write-one-to-clear of that status bit, the bit stays set.
- R11: `bank_irq[b]` is high exactly when group-enable bit b is set and at least one status bit of pins 16b to 16b+15 is set.
- R12: The enable-set and enable-clear ports change only the masked rise or fall enable bits. Each pair of ports reads back its current enable vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 64 | Pad levels seen by the block |
| pin_out | output | 64 | Output levels driven to the pads |
| pin_oe | output | 64 | Output driver enable per pin, high = driving |
| bank_irq | output | 4 | One interrupt line per group of 16 pins |

## Verification
The hardest case to reach is an edge captured on the same clock edge as a software clear of the same status bit. The bench sets the bit with one transition first. It then makes the opposite transition on the pin and waits two falling clock edges. After that it issues the clear write so that the write and the synchronised edge fall on the same rising edge, and it confirms that the bit survives. Group gating is checked by leaving a status bit set while the group enable is switched off and on again.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

   localparam int unsigned REG_W     = 32;
   localparam int unsigned SET_WORDS = 10;

   // word index of each register inside one register set
   localparam int unsigned W_DIR   = 0;
   localparam int unsigned W_OUT   = 1;
   localparam int unsigned W_OSET  = 2;
   localparam int unsigned W_OCLR  = 3;
   localparam int unsigned W_IN    = 4;
   localparam int unsigned W_RSET  = 5;
   localparam int unsigned W_RCLR  = 6;
   localparam int unsigned W_FSET  = 7;
   localparam int unsigned W_FCLR  = 8;
   localparam int unsigned W_STAT  = 9;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync needs at least two stages");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= '0;
            else        stage_q[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= '0;
            else        stage_q[i] <= stage_q[i-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regset.sv
module gpio_regset
   import gpio_edge_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned BASE        = 16,
   parameter int unsigned WIDTH       = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wdata,
   input  logic [WIDTH-1:0]  pad_lvl,
   output logic [WIDTH-1:0]  out_lvl,
   output logic [WIDTH-1:0]  drv_en,
   output logic [WIDTH-1:0]  stat,
   output logic [REG_W-1:0]  rdata
);

   localparam int unsigned SPAN = SET_WORDS * 4;
   localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(BASE);
   localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(BASE + SPAN);

   if (WIDTH > REG_W) begin : g_bad_width
      $error("register set wider than the bus");
   end

   logic [ADDR_W:0]    offs;
   logic               in_range;
   logic [SET_WORDS-1:0] hit;
   logic [WIDTH-1:0]   wmask;

   assign offs     = {1'b0, addr} - LO;
   assign in_range = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
   assign wmask    = wdata[WIDTH-1:0];

   for (genvar k = 0; k < SET_WORDS; k++) begin : g_hit
      assign hit[k] = in_range && (offs == (ADDR_W+1)'(k * 4));
   end

   logic wr_dir, wr_oset, wr_oclr, wr_rset, wr_rclr, wr_fset, wr_fclr, wr_stat;
   assign wr_dir  = wr_en && hit[W_DIR];
   assign wr_oset = wr_en && hit[W_OSET];
   assign wr_oclr = wr_en && hit[W_OCLR];
   assign wr_rset = wr_en && hit[W_RSET];
   assign wr_rclr = wr_en && hit[W_RCLR];
   assign wr_fset = wr_en && hit[W_FSET];
   assign wr_fclr = wr_en && hit[W_FCLR];
   assign wr_stat = wr_en && hit[W_STAT];

   logic [WIDTH-1:0] dir_q, out_q, rise_q, fall_q, stat_q;
   logic [WIDTH-1:0] lvl_s, lvl_prev, ev;

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_lvl),
      .q     (lvl_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_prev <= '0;
      else        lvl_prev <= lvl_s;
   end

   assign ev = (rise_q & lvl_s & ~lvl_prev) | (fall_q & ~lvl_s & lvl_prev);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '1;
         out_q  <= '0;
         rise_q <= '0;
         fall_q <= '0;
         stat_q <= '0;
      end else begin
         if (wr_dir)  dir_q  <= wmask;
         if (wr_oset) out_q  <= out_q | wmask;
         if (wr_oclr) out_q  <= out_q & ~wmask;
         if (wr_rset) rise_q <= rise_q | wmask;
         if (wr_rclr) rise_q <= rise_q & ~wmask;
         if (wr_fset) fall_q <= fall_q | wmask;
         if (wr_fclr) fall_q <= fall_q & ~wmask;
         // a fresh edge outranks a clear of the same bit
         stat_q <= (stat_q & ~(wr_stat ? wmask : '0)) | ev;
      end
   end

   always_comb begin
      rdata = '0;
      if (hit[W_DIR])                  rdata = REG_W'(dir_q);
      if (hit[W_OUT] || hit[W_OSET] || hit[W_OCLR]) rdata = REG_W'(out_q);
      if (hit[W_IN])                   rdata = REG_W'(lvl_s);
      if (hit[W_RSET] || hit[W_RCLR])  rdata = REG_W'(rise_q);
      if (hit[W_FSET] || hit[W_FCLR])  rdata = REG_W'(fall_q);
      if (hit[W_STAT])                 rdata = REG_W'(stat_q);
   end

   assign out_lvl = out_q;
   assign drv_en  = ~dir_q;
   assign stat    = stat_q;

   // outputs move only through the set/clear ports
   assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_oset || wr_oclr) |=> $stable(out_q));

   // without a clear write no status bit drops
   assert_stat_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

   // every captured edge lands in status even under a clear
   assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ev != '0) |=> ((stat_q & $past(ev)) == $past(ev)));

   // no status bit appears without an enabled edge
   assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_s == lvl_s) |=> ((stat_q & ~$past(stat_q) & ~$past(ev)) == '0));

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
   import gpio_edge_pkg::*;
#(
   parameter int unsigned NUM_PINS     = 64,
   parameter int unsigned SET_PINS     = 32,
   parameter int unsigned BANK_PINS    = 16,
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned SET_BASE     = 16,
   parameter int unsigned BANK_EN_ADDR = 8,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic                          bus_we,
   input  logic [REG_W-1:0]              bus_wdata,
   output logic [REG_W-1:0]              bus_rdata,
   input  logic [NUM_PINS-1:0]           pin_in,
   output logic [NUM_PINS-1:0]           pin_out,
   output logic [NUM_PINS-1:0]           pin_oe,
   output logic [NUM_PINS/BANK_PINS-1:0] bank_irq
);

   localparam int unsigned NUM_SETS  = NUM_PINS / SET_PINS;
   localparam int unsigned NUM_BANKS = NUM_PINS / BANK_PINS;
   localparam int unsigned STRIDE    = SET_WORDS * 4;

   if (NUM_PINS % SET_PINS != 0 || SET_PINS % BANK_PINS != 0) begin : g_bad_split
      $error("pin count must split evenly into sets and banks");
   end
   if (SET_PINS > REG_W || NUM_BANKS > REG_W) begin : g_bad_reg
      $error("set or bank count exceeds register width");
   end
   if (SET_BASE + NUM_SETS * STRIDE > (1 << ADDR_W) || BANK_EN_ADDR + 4 > SET_BASE) begin : g_bad_map
      $error("address map does not fit");
   end

   localparam logic [ADDR_W-1:0] BEN_A = ADDR_W'(BANK_EN_ADDR);

   logic [NUM_BANKS-1:0] bank_en_q;
   logic                 ben_hit;
   logic [NUM_PINS-1:0]  stat_all;
   logic [REG_W-1:0]     set_rdata [NUM_SETS];

   assign ben_hit = (bus_addr == BEN_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 bank_en_q <= '0;
      else if (bus_we && ben_hit) bank_en_q <= bus_wdata[NUM_BANKS-1:0];
   end

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      gpio_regset #(
         .ADDR_W      (ADDR_W),
         .BASE        (SET_BASE + s * STRIDE),
         .WIDTH       (SET_PINS),
         .SYNC_STAGES (SYNC_STAGES)
      ) u_set (
         .clk     (clk),
         .rst_n   (rst_n),
         .addr    (bus_addr),
         .wr_en   (bus_we),
         .wdata   (bus_wdata),
         .pad_lvl (pin_in[s*SET_PINS +: SET_PINS]),
         .out_lvl (pin_out[s*SET_PINS +: SET_PINS]),
         .drv_en  (pin_oe[s*SET_PINS +: SET_PINS]),
         .stat    (stat_all[s*SET_PINS +: SET_PINS]),
         .rdata   (set_rdata[s])
      );
   end

   always_comb begin
      bus_rdata = ben_hit ? REG_W'(bank_en_q) : '0;
      for (int s = 0; s < NUM_SETS; s++) bus_rdata = bus_rdata | set_rdata[s];
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign bank_irq[b] = bank_en_q[b] && (|stat_all[b*BANK_PINS +: BANK_PINS]);

      // a disabled group drops its line on the next cycle
      assert_bank_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && ben_hit && !bus_wdata[b]) |=> !bank_irq[b]);
   end

endmodule

// File: tb/gpio_edge_ctrl_tb.sv
module gpio_edge_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:0] pin_in = '0;
   logic [63:0] pin_out, pin_oe;
   logic [3:0]  bank_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   gpio_edge_ctrl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .bank_irq  (bank_irq)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a,
                         input logic [31:0] mask, input logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(tag, 64'(bus_rdata & mask), 64'(exp));
   endtask

   // fields: write flag, address, data, expected read, requirement number
   localparam int NV = 19;
   localparam logic [80:0] VEC [NV] = '{
      {1'b0, 8'h10, 32'h0,        32'hFFFFFFFF, 8'd1},  // R1 set0 dir
      {1'b0, 8'h38, 32'h0,        32'hFFFFFFFF, 8'd1},  // R1 set1 dir
      {1'b0, 8'h34, 32'h0,        32'h00000000, 8'd1},  // R1 status
      {1'b1, 8'h10, 32'hFFFF0000, 32'h0,        8'd3},  // R3 pins 0-15 out
      {1'b0, 8'h10, 32'h0,        32'hFFFF0000, 8'd3},
      {1'b1, 8'h18, 32'h000000F0, 32'h0,        8'd4},  // R4 set
      {1'b0, 8'h14, 32'h0,        32'h000000F0, 8'd4},
      {1'b1, 8'h1C, 32'h00000030, 32'h0,        8'd4},  // R4 clear
      {1'b0, 8'h14, 32'h0,        32'h000000C0, 8'd4},
      {1'b1, 8'h14, 32'hFFFFFFFF, 32'h0,        8'd4},  // R4 direct write ignored
      {1'b0, 8'h14, 32'h0,        32'h000000C0, 8'd4},
      {1'b1, 8'h4C, 32'h00000101, 32'h0,        8'd12}, // R12 rise set
      {1'b1, 8'h50, 32'h00000001, 32'h0,        8'd12}, // R12 rise clear
      {1'b0, 8'h4C, 32'h0,        32'h00000100, 8'd12},
      {1'b1, 8'h08, 32'h000000FF, 32'h0,        8'd2},  // R2 group enable
      {1'b0, 8'h08, 32'h0,        32'h0000000F, 8'd2},
      {1'b0, 8'h04, 32'h0,        32'h00000000, 8'd2},  // R2 unmapped
      {1'b1, 8'h50, 32'h00000100, 32'h0,        8'd12},
      {1'b0, 8'h50, 32'h0,        32'h00000000, 8'd12}
   };

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state at the ports
      chk("R1 pin_oe", pin_oe, 64'h0);
      chk("R1 pin_out", pin_out, 64'h0);
      chk("R1 bank_irq", 64'(bank_irq), 64'h0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][80]) begin
            bus_wr(VEC[i][79:72], VEC[i][71:40]);
         end else begin
            rd_chk($sformatf("R%0d vector %0d", VEC[i][7:0], i),
                   VEC[i][79:72], 32'hFFFFFFFF, VEC[i][39:8]);
            @(negedge clk);
         end
      end

      // R3 and R4 at the pads
      chk("R3 pin_oe", 64'(pin_oe[31:0]), 64'h0000FFFF);
      chk("R4 pin_out", 64'(pin_out[31:0]), 64'h000000C0);

      // R5 two-stage input latency, pin 0 is an output
      pin_in[0] = 1'b1;
      @(negedge clk);
      rd_chk("R5 before sync", 8'h20, 32'h1, 32'h0);
      @(negedge clk);
      rd_chk("R5 after sync", 8'h20, 32'h1, 32'h1);

      // R6 rising edge on pin 2
      bus_wr(8'h24, 32'h4);
      pin_in[2] = 1'b1;
      repeat (2) @(negedge clk);
      rd_chk("R6 not yet", 8'h34, 32'hFFFFFFFF, 32'h0);
      @(negedge clk);
      rd_chk("R6 status", 8'h34, 32'hFFFFFFFF, 32'h4);
      chk("R11 group 0 line", 64'(bank_irq), 64'h1);

      // R9 write-one-to-clear
      bus_wr(8'h34, 32'h0);
      rd_chk("R9 zero write keeps", 8'h34, 32'hFFFFFFFF, 32'h4);
      bus_wr(8'h34, 32'h4);
      rd_chk("R9 one write clears", 8'h34, 32'hFFFFFFFF, 32'h0);
      chk("R11 line drops", 64'(bank_irq), 64'h0);

      // R8 edge without enable
      pin_in[3] = 1'b1;
      repeat (4) @(negedge clk);
      rd_chk("R8 no enable", 8'h34, 32'hFFFFFFFF, 32'h0);
      chk("R8 no line", 64'(bank_irq), 64'h0);

      // R7 both enables on set1 pin 20 (pin 52, group 3)
      bus_wr(8'h54, 32'h00100000);
      bus_wr(8'h4C, 32'h00100000);
      pin_in[52] = 1'b1;
      repeat (3) @(negedge clk);
      rd_chk("R7 rise with both", 8'h5C, 32'hFFFFFFFF, 32'h00100000);
      chk("R11 group 3 line", 64'(bank_irq), 64'h8);
      bus_wr(8'h5C, 32'h00100000);
      rd_chk("R9 cleared set1", 8'h5C, 32'hFFFFFFFF, 32'h0);
      pin_in[52] = 1'b0;
      repeat (3) @(negedge clk);
      rd_chk("R7 fall with both", 8'h5C, 32'hFFFFFFFF, 32'h00100000);

      // R7 fall-only on pin 3
      bus_wr(8'h2C, 32'h8);
      pin_in[3] = 1'b0;
      repeat (3) @(negedge clk);
      rd_chk("R7 fall only", 8'h34, 32'hFFFFFFFF, 32'h8);
      chk("R11 groups 0 and 3", 64'(bank_irq), 64'h9);
      bus_wr(8'h34, 32'h8);
      pin_in[3] = 1'b1;
      repeat (4) @(negedge clk);
      rd_chk("R8 rise ignored when fall only", 8'h34, 32'hFFFFFFFF, 32'h0);

      // R11 gating while status stays set
      bus_wr(8'h08, 32'h7);
      chk("R11 gated off", 64'(bank_irq), 64'h0);
      rd_chk("R11 status kept", 8'h5C, 32'hFFFFFFFF, 32'h00100000);
      bus_wr(8'h08, 32'hF);
      chk("R11 gated on", 64'(bank_irq), 64'h8);

      // R10 edge captured on the same edge as the clear
      pin_in[52] = 1'b1;
      repeat (2) @(negedge clk);
      bus_wr(8'h5C, 32'h00100000);
      rd_chk("R10 event wins", 8'h5C, 32'hFFFFFFFF, 32'h00100000);
      bus_wr(8'h5C, 32'h00100000);
      rd_chk("R10 later clear works", 8'h5C, 32'hFFFFFFFF, 32'h0);
      chk("R11 all low", 64'(bank_irq), 64'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule